// File: doc/BRIEF.md
# Bit-Test-and-Skip Execution Unit

This unit carries out the two conditional-skip instructions of a small 8-bit microcontroller core. Each of them tests one bit of a data-memory byte. A start pulse hands it three things: the instruction word to execute, the word the fetch stage has already prefetched behind it, and the program counter of the executing word. The unit decodes the word and forms a 12-bit data address using one of three addressing modes. It reads the byte in the second quarter of the cycle and evaluates the bit in the third quarter.

When the skip condition holds, the prefetched instruction is discarded and no-operation cycles run in its place. A two-word follower costs one extra cycle. When the sequence ends, the unit pulses `done` and reports the next program counter, the number of instruction cycles used and whether a skip happened. One instruction cycle is four clocks, one clock per quarter-phase. No status flags are affected.

Top module: `bts_skip_unit`

## Requirements
- R1: Word bits [15:12] equal to 4'b1011 select skip-if-clear and 4'b1010 select skip-if-set. Bits [11:9] give the tested bit number, bit [8] is the access flag, and bits [7:0] are the file address.
- R2: Skip-if-clear skips when the tested bit of the read byte is 0. Skip-if-set skips when that bit is 1.
- R3: With the access flag at 1, the read address is {bank_sel, file}, whatever `ext_en` is.
- R4: With the access flag at 0 and indexed mode not in force, file addresses 0x00–0x5F read 0x000+file and 0x60–0xFF read 0xF00+file.
- R5: With the access flag at 0, `ext_en` high and file ≤ 0x5F, the read address is index_base + file, taken modulo 4096.
- R6: An accepted start runs quarter-phases Q1..Q4 on consecutive clocks. `rd_en` is high only in Q2 of the test cycle. `done` rises 4×cycle_cnt clocks after the accepting edge, and `busy` is low while `done` is high. After reset, `busy`, `done`, `pc_next` and `cycle_cnt` are 0.
- R7: Without a skip, the instruction takes 1 cycle, `skip`=0 and `pc_next`=pc_in+1. This holds even if the follower is two words long.
- R8: A skip over a one-word follower takes 2 cycles, with `squash` high for the 4 clocks of the no-operation cycle. It gives `skip`=1 and `pc_next`=pc_in+2.
- R9: A follower is two words long when bits [15:12]=4'hC, or bits [15:9]=7'b1110110, or bits [15:8]=8'hEF, or bits [15:6]=10'b1110111000. A skip over such a follower takes 3 cycles, with 8 clocks of `squash`. It gives `pc_next`=pc_in+3, modulo 2^16.
- R10: A word that is neither opcode completes in 1 cycle with no register read, no skip and `pc_next`=pc_in+1.
- R11: A start pulse while `busy` is high is ignored. The running instruction completes with its own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one quarter-phase per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing `exec_word` (accepted when idle) |
| exec_word | input | 16 | Instruction word to execute |
| fetch_word | input | 16 | Prefetched word that follows it |
| pc_in | input | 16 | Word address of `exec_word` |
| bank_sel | input | 4 | Bank select register value |
| ext_en | input | 1 | Extended instruction set enabled |
| index_base | input | 12 | Base pointer for indexed literal offset mode |
| rd_en | output | 1 | Register-file read strobe (Q2) |
| rd_addr | output | 12 | Register-file read address |
| rd_data | input | 8 | Byte returned for `rd_addr`, same clock |
| busy | output | 1 | Instruction in progress |
| phase | output | 2 | Current quarter-phase, 0=Q1..3=Q4 |
| squash | output | 1 | Discarded no-operation cycle in progress |
| done | output | 1 | One-clock completion pulse |
| skip | output | 1 | Last instruction skipped its follower |
| pc_next | output | 16 | Program counter to use next |
| cycle_cnt | output | 2 | Instruction cycles used by the last instruction |

## Verification
The bench sweeps all eight bit positions under both opcodes and derives every expected address, outcome, latency and squash length from its own model. Several cases sit exactly on the addressing boundaries: file 0x5F against 0x60 with `ext_en` high, an indexed sum that wraps past 0xFFF, and a set access flag with `ext_en` high. An address former that compared with the wrong bound, or let the extended mode override banking, would read the wrong byte and report a wrong address. Skips are forced over each kind of two-word follower, and a non-skip over a two-word follower is also run, together with a program counter that wraps. A design that counted follower words wrongly would give a wrong cycle count, a wrong squash length or a wrong `pc_next`. A start pulse injected mid-instruction would corrupt the reported results of an implementation that restarted.

// File: rtl/bts_pkg.sv
// Shared constants, types and follower-length decode for the bit-test-and-skip unit.
// Assumes 16-bit program words and 8-bit file fields.
package bts_pkg;
    localparam int FILE_W = 8;

    localparam logic [3:0] OP_SKIP_CLR = 4'b1011;
    localparam logic [3:0] OP_SKIP_SET = 4'b1010;

    localparam logic [1:0] PH_Q1 = 2'd0;
    localparam logic [1:0] PH_Q2 = 2'd1;
    localparam logic [1:0] PH_Q3 = 2'd2;
    localparam logic [1:0] PH_Q4 = 2'd3;

    typedef enum logic [1:0] {ST_IDLE, ST_TEST, ST_SQUASH} seq_state_t;

    typedef struct packed {
        logic              is_bts;
        logic              skip_if_set;
        logic [2:0]        bit_sel;
        logic              acc;
        logic [FILE_W-1:0] file;
    } bts_op_t;

    // True when the given word opens a two-word instruction.
    function automatic logic two_word(input logic [15:0] w);
        return (w[15:12] == 4'hC) || (w[15:9] == 7'b1110110) ||
               (w[15:8] == 8'hEF) || (w[15:6] == 10'b1110111000);
    endfunction
endpackage

// File: rtl/bts_decode.sv
// Combinational field extraction for the two bit-test-and-skip opcodes.
// Assumes the word is held stable by the caller for the whole instruction.
module bts_decode
    import bts_pkg::*;
(
    input  logic [15:0] word,
    output bts_op_t     op
);
    // Split the word into opcode class, bit number, access flag and file address.
    always_comb begin
        op.is_bts      = (word[15:12] == OP_SKIP_CLR) || (word[15:12] == OP_SKIP_SET);
        op.skip_if_set = (word[15:12] == OP_SKIP_SET);
        op.bit_sel     = word[11:9];
        op.acc         = word[8];
        op.file        = word[7:0];
    end
endmodule

// File: rtl/bts_addr_gen.sv
// Forms the data-memory address from file field, access flag, bank and index base.
// Assumes ACCESS_SPLIT is the first file address of the special-function window.
module bts_addr_gen
    import bts_pkg::*;
#(
    parameter int               BANK_W       = 4,
    parameter logic [FILE_W-1:0] ACCESS_SPLIT = 8'h60,
    localparam int              ADDR_W       = BANK_W + FILE_W
) (
    input  logic              acc,
    input  logic [FILE_W-1:0] file,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              ext_en,
    input  logic [ADDR_W-1:0] index_base,
    output logic [ADDR_W-1:0] addr
);
    logic low_window;
    assign low_window = (file < ACCESS_SPLIT);

    // Choose banked, indexed or access-bank addressing.
    always_comb begin
        if (acc)
            addr = {bank_sel, file};
        else if (ext_en && low_window)
            addr = index_base + ADDR_W'(file);
        else if (low_window)
            addr = {{BANK_W{1'b0}}, file};
        else
            addr = {{BANK_W{1'b1}}, file};
    end
endmodule

// File: rtl/bts_sequencer.sv
// Quarter-phase sequencer: read in Q2, bit test in Q3, decision in Q4, then
// one or two squashed no-operation cycles when the skip condition holds.
// Assumes rd_data answers rd_addr within the same clock.
module bts_sequencer
    import bts_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [PC_W-1:0] pc_in,
    input  logic            is_bts,
    input  logic            skip_if_set,
    input  logic [2:0]      bit_sel,
    input  logic            follower_two,
    input  logic [7:0]      rd_data,
    output logic            accept,
    output logic            busy,
    output logic [1:0]      phase,
    output logic            rd_en,
    output logic            squash,
    output logic            done,
    output logic            skip,
    output logic [PC_W-1:0] pc_next,
    output logic [1:0]      cycle_cnt
);
    seq_state_t      state;
    logic [7:0]      data_q;
    logic            hit_q;
    logic [1:0]      nop_total;
    logic [1:0]      nop_left;
    logic [PC_W-1:0] pc_q;
    logic            hit_w;

    assign busy   = (state != ST_IDLE);
    assign accept = start && !busy;
    assign rd_en  = (state == ST_TEST) && (phase == PH_Q2) && is_bts;
    assign squash = (state == ST_SQUASH);
    assign hit_w  = skip_if_set ? data_q[bit_sel] : !data_q[bit_sel];

    // Advance the quarter-phase, capture operand and bit result, sequence squash cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_Q1;
            data_q    <= '0;
            hit_q     <= 1'b0;
            nop_total <= 2'd0;
            nop_left  <= 2'd0;
            pc_q      <= '0;
            done      <= 1'b0;
            skip      <= 1'b0;
            pc_next   <= '0;
            cycle_cnt <= 2'd0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_TEST;
                        phase <= PH_Q1;
                        pc_q  <= pc_in;
                        hit_q <= 1'b0;
                    end
                end
                ST_TEST: begin
                    phase <= phase + 2'd1;
                    if (rd_en)
                        data_q <= rd_data;
                    if (phase == PH_Q3)
                        hit_q <= is_bts && hit_w;
                    if (phase == PH_Q4) begin
                        if (hit_q) begin
                            state     <= ST_SQUASH;
                            nop_total <= follower_two ? 2'd2 : 2'd1;
                            nop_left  <= follower_two ? 2'd2 : 2'd1;
                        end else begin
                            state     <= ST_IDLE;
                            done      <= 1'b1;
                            skip      <= 1'b0;
                            pc_next   <= pc_q + PC_W'(1);
                            cycle_cnt <= 2'd1;
                        end
                    end
                end
                ST_SQUASH: begin
                    phase <= phase + 2'd1;
                    if (phase == PH_Q4) begin
                        if (nop_left == 2'd1) begin
                            state     <= ST_IDLE;
                            done      <= 1'b1;
                            skip      <= 1'b1;
                            pc_next   <= pc_q + PC_W'(nop_total + 2'd1);
                            cycle_cnt <= nop_total + 2'd1;
                        end else begin
                            nop_left <= nop_left - 2'd1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_READ_THEN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (phase == PH_Q3) && !squash); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (phase == $past(phase) + 2'd1)); // R6
    AST_NOSKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !skip) |-> (cycle_cnt == 2'd1)); // R7
    AST_SKIP_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skip) |-> (cycle_cnt >= 2'd2)); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(pc_q)); // R11
endmodule

// File: rtl/bts_skip_unit.sv
// Top of the bit-test-and-skip execution unit: latches the executing and
// prefetched words on an accepted start, decodes, forms the read address and
// hands the bit test and skip sequencing to the sequencer.
// Assumes a combinational register-file read answering within one clock.
module bts_skip_unit
    import bts_pkg::*;
#(
    parameter int               PC_W         = 16,
    parameter int               BANK_W       = 4,
    parameter logic [FILE_W-1:0] ACCESS_SPLIT = 8'h60,
    localparam int              ADDR_W       = BANK_W + FILE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       exec_word,
    input  logic [15:0]       fetch_word,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              ext_en,
    input  logic [ADDR_W-1:0] index_base,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic [1:0]        phase,
    output logic              squash,
    output logic              done,
    output logic              skip,
    output logic [PC_W-1:0]   pc_next,
    output logic [1:0]        cycle_cnt
);
    logic [15:0]       exec_q;
    logic [15:0]       fetch_q;
    logic [BANK_W-1:0] bank_q;
    logic              ext_q;
    logic [ADDR_W-1:0] base_q;
    logic              accept;
    bts_op_t           op;

    // Hold the instruction context for the whole multi-cycle sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q  <= '0;
            fetch_q <= '0;
            bank_q  <= '0;
            ext_q   <= 1'b0;
            base_q  <= '0;
        end else if (accept) begin
            exec_q  <= exec_word;
            fetch_q <= fetch_word;
            bank_q  <= bank_sel;
            ext_q   <= ext_en;
            base_q  <= index_base;
        end
    end

    bts_decode u_decode (
        .word (exec_q),
        .op   (op)
    );

    bts_addr_gen #(
        .BANK_W       (BANK_W),
        .ACCESS_SPLIT (ACCESS_SPLIT)
    ) u_addr (
        .acc        (op.acc),
        .file       (op.file),
        .bank_sel   (bank_q),
        .ext_en     (ext_q),
        .index_base (base_q),
        .addr       (rd_addr)
    );

    bts_sequencer #(
        .PC_W (PC_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .pc_in        (pc_in),
        .is_bts       (op.is_bts),
        .skip_if_set  (op.skip_if_set),
        .bit_sel      (op.bit_sel),
        .follower_two (two_word(fetch_q)),
        .rd_data      (rd_data),
        .accept       (accept),
        .busy         (busy),
        .phase        (phase),
        .rd_en        (rd_en),
        .squash       (squash),
        .done         (done),
        .skip         (skip),
        .pc_next      (pc_next),
        .cycle_cnt    (cycle_cnt)
    );

    AST_SQUASH_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> !rd_en); // R8
    AST_BANKED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && op.acc) |-> (rd_addr[ADDR_W-1:FILE_W] == bank_q)); // R3
    AST_ACCESS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !op.acc && (op.file >= ACCESS_SPLIT)) |-> (rd_addr[ADDR_W-1:FILE_W] == {BANK_W{1'b1}})); // R4
endmodule

// File: tb/tb_bts_skip_unit.sv
module tb_bts_skip_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] exec_word = '0;
    logic [15:0] fetch_word = '0;
    logic [15:0] pc_in = '0;
    logic [3:0]  bank_sel = '0;
    logic        ext_en = 1'b0;
    logic [11:0] index_base = '0;
    logic        rd_en;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data;
    logic        busy;
    logic [1:0]  phase;
    logic        squash;
    logic        done;
    logic        skip;
    logic [15:0] pc_next;
    logic [1:0]  cycle_cnt;

    int total = 0;
    int bad = 0;
    bit reported = 0;

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    assign rd_data = mem_byte(rd_addr);

    bts_skip_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .exec_word(exec_word),
        .fetch_word(fetch_word), .pc_in(pc_in), .bank_sel(bank_sel),
        .ext_en(ext_en), .index_base(index_base), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .phase(phase),
        .squash(squash), .done(done), .skip(skip), .pc_next(pc_next),
        .cycle_cnt(cycle_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic two_w(input logic [15:0] w);
        return (w[15:12] == 4'hC) || (w[15:9] == 7'b1110110) ||
               (w[15:8] == 8'hEF) || (w[15:6] == 10'b1110111000);
    endfunction

    function automatic logic [11:0] ref_addr(input logic [15:0] w, input logic [3:0] bk,
                                             input logic ex, input logic [11:0] bs);
        if (w[8]) return {bk, w[7:0]};
        if (ex && w[7:0] <= 8'h5F) return bs + {4'h0, w[7:0]};
        if (w[7:0] < 8'h60) return {4'h0, w[7:0]};
        return {4'hF, w[7:0]};
    endfunction

    // Picks the opcode that makes the test skip (want=1) or not for the given fields.
    function automatic logic [15:0] pick_op(input logic want, input logic [11:0] fields,
                                            input logic [3:0] bk, input logic ex,
                                            input logic [11:0] bs);
        logic [11:0] a;
        logic        bv;
        a  = ref_addr({4'hA, fields}, bk, ex, bs);
        bv = mem_byte(a)[fields[11:9]];
        return {(bv == want) ? 4'hA : 4'hB, fields};
    endfunction

    // Runs one instruction and checks address, outcome, latency, squash length and PC.
    task automatic run_case(input logic [15:0] w, input logic [15:0] nxt,
                            input logic [3:0] bk, input logic ex, input logic [11:0] bs,
                            input logic [15:0] pc, input string req, input bit poke);
        logic        e_is, e_skip, bv;
        logic [11:0] e_addr, got_addr;
        int          e_cyc, n, reads, sq;
        logic [15:0] e_pc;
        e_is   = (w[15:12] == 4'hA) || (w[15:12] == 4'hB);
        e_addr = ref_addr(w, bk, ex, bs);
        bv     = mem_byte(e_addr)[w[11:9]];
        e_skip = e_is && ((w[15:12] == 4'hA) ? bv : !bv);
        e_cyc  = e_skip ? (two_w(nxt) ? 3 : 2) : 1;
        e_pc   = pc + 16'(e_cyc);
        @(negedge clk);
        exec_word = w; fetch_word = nxt; bank_sel = bk; ext_en = ex;
        index_base = bs; pc_in = pc; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0; reads = 0; sq = 0; got_addr = '0;
        while (!done && n < 40) begin
            if (rd_en) begin reads++; got_addr = rd_addr; end
            if (squash) sq++;
            if (poke && n == 1) begin
                start = 1'b1; exec_word = 16'hB0FF; pc_in = 16'h7777;
            end
            if (poke && n == 2) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk(reads == (e_is ? 1 : 0), req, "read strobes", reads, e_is ? 1 : 0);
        if (e_is) chk(got_addr == e_addr, req, "read address", int'(got_addr), int'(e_addr));
        chk(n == 4 * e_cyc, req, "latency clocks", n, 4 * e_cyc);
        chk(done && int'(cycle_cnt) == e_cyc, req, "cycle count", int'(cycle_cnt), e_cyc);
        chk(skip == e_skip, req, "skip flag", int'(skip), int'(e_skip));
        chk(pc_next == e_pc, req, "next pc", int'(pc_next), int'(e_pc));
        chk(sq == 4 * (e_cyc - 1), req, "squash clocks", sq, 4 * (e_cyc - 1));
        chk(!busy, req, "busy at done", int'(busy), 0);
    endtask

    // R1 R2: both opcodes across all bit positions, banked addressing.
    task automatic t_all_bits;
        for (int b = 0; b < 8; b++) begin
            run_case({4'hB, 3'(b), 1'b1, 8'h21 + 8'(b)}, 16'h0F00, 4'h3, 1'b0, 12'h000,
                     16'h0100, "R1", 1'b0);
            run_case({4'hA, 3'(b), 1'b1, 8'h21 + 8'(b)}, 16'h0F00, 4'h3, 1'b0, 12'h000,
                     16'h0200, "R2", 1'b0);
        end
    endtask

    // R3 R4 R5: the addressing modes and their boundaries.
    task automatic t_addressing;
        run_case({4'hB, 3'd2, 1'b0, 8'h10}, 16'h0000, 4'h7, 1'b0, 12'h300, 16'h10, "R4", 1'b0);
        run_case({4'hA, 3'd5, 1'b0, 8'h80}, 16'h0000, 4'h7, 1'b0, 12'h300, 16'h20, "R4", 1'b0);
        run_case({4'hB, 3'd6, 1'b0, 8'h60}, 16'h0000, 4'h7, 1'b1, 12'h300, 16'h30, "R4", 1'b0);
        run_case({4'hA, 3'd1, 1'b0, 8'h5F}, 16'h0000, 4'h7, 1'b1, 12'h300, 16'h40, "R5", 1'b0);
        run_case({4'hB, 3'd4, 1'b0, 8'h20}, 16'h0000, 4'h7, 1'b1, 12'hFF0, 16'h50, "R5", 1'b0);
        run_case({4'hA, 3'd3, 1'b1, 8'h10}, 16'h0000, 4'hC, 1'b1, 12'h300, 16'h60, "R3", 1'b0);
    endtask

    // R7 R8 R9: forced skips over each follower kind, and a non-skip over a long follower.
    task automatic t_followers;
        run_case(pick_op(1'b1, 12'h345, 4'h1, 1'b0, 12'h0), 16'h2A00, 4'h1, 1'b0, 12'h0, 16'h0400, "R8", 1'b0);
        run_case(pick_op(1'b1, 12'h345, 4'h1, 1'b0, 12'h0), 16'hC123, 4'h1, 1'b0, 12'h0, 16'h0500, "R9", 1'b0);
        run_case(pick_op(1'b1, 12'hB3A, 4'h1, 1'b0, 12'h0), 16'hEC05, 4'h1, 1'b0, 12'h0, 16'h0600, "R9", 1'b0);
        run_case(pick_op(1'b1, 12'h7F1, 4'h2, 1'b0, 12'h0), 16'hEF00, 4'h2, 1'b0, 12'h0, 16'h0700, "R9", 1'b0);
        run_case(pick_op(1'b1, 12'h1E2, 4'h2, 1'b0, 12'h0), 16'hEE12, 4'h2, 1'b0, 12'h0, 16'hFFFF, "R9", 1'b0);
        run_case(pick_op(1'b0, 12'h345, 4'h1, 1'b0, 12'h0), 16'hC123, 4'h1, 1'b0, 12'h0, 16'h0800, "R7", 1'b0);
    endtask

    // R10: an unrelated opcode completes in one cycle without reading.
    task automatic t_other_opcode;
        run_case(16'h2A55, 16'hC000, 4'h0, 1'b0, 12'h0, 16'h0900, "R10", 1'b0);
    endtask

    // R11: a start during a running skip sequence changes nothing.
    task automatic t_busy_start;
        run_case(pick_op(1'b1, 12'h345, 4'h1, 1'b0, 12'h0), 16'hC123, 4'h1, 1'b0, 12'h0, 16'h0A00, "R11", 1'b1);
        repeat (6) @(negedge clk);
        chk(!busy && !done, "R11", "idle after ignored start", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state.
        chk(!busy && !done, "R6", "busy/done after reset", int'({busy, done}), 0);
        chk(pc_next == 16'h0 && cycle_cnt == 2'd0, "R6", "pc/cycles after reset", int'(pc_next), 0);
        rst_n = 1'b1;
        t_all_bits();
        t_addressing();
        t_followers();
        t_other_opcode();
        t_busy_start();
        report();
    end
endmodule